// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block turns the single-bit output of an infrared demodulator into a stream of one-byte run-length symbols. A divider derives a slow sample tick from the block clock. On each tick the re-timed input level is sampled. A debounce stage removes short excursions. Each settled level is then measured in samples and reported as a symbol that carries the level and the length of the run.

A long stretch of space marks the end of a packet. The block raises a one-cycle packet-end pulse and stops reporting space until the next pulse begins. A consumer, usually a small FIFO, collects the symbols. It uses the packet-end pulse to hand a complete burst to a protocol decoder.

Top module: `ir_runlen_sampler`

## Requirements
- R1: While both enables are high, a sample tick occurs once every SAMPLE_DIV clocks. Symbols and packet-end pulses change only in the clock that follows a tick, so two full-length symbols of one long run are exactly 128·SAMPLE_DIV clocks apart.
- R2: Each symbol is one byte. Bit 7 is the level of the run (1 = pulse, 0 = space). Bits 6:0 are the number of samples in the run minus one. The symbol is emitted in the sample that starts the next run.
- R3: When a run reaches its 129th sample, the symbol 0x7F with the run's level in bit 7 (0xFF for pulse, 0x7F for space) is emitted. Counting then restarts at that sample for the same level.
- R4: With pol_inv high, the pin is inverted before sampling, so a low pin is a pulse. With pol_inv low, a high pin is a pulse.
- R5: A level change is accepted only after the new level has been seen for noise_thr consecutive samples (0 acts as 1). A shorter excursion produces no symbol, and its samples count toward the surrounding run.
- R6: When space lasts (idle_thr+1)·128 samples and one more sample arrives, pkt_end pulses for one clock. This happens in the same clock as the final 0x7F space symbol.
- R7: After a packet end, after reset and after enabling, the block is idle. No space symbol is emitted, and the next pulse starts a packet without emitting a symbol for the space before it.
- R8: While glb_en or rx_en is low, no symbol and no pkt_end is produced, whatever the pin does. On re-enable the block starts idle.
- R9: During reset, sym_valid, pkt_end and sym_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (base clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| pol_inv | input | 1 | Invert raw pin before sampling |
| noise_thr | input | 6 | Samples a new level must persist |
| idle_thr | input | 8 | Packet-end threshold, in units of 128 space samples, minus one |
| ir_pin | input | 1 | Raw demodulator output, asynchronous |
| sym_data | output | 8 | Run-length symbol {level, length-1} |
| sym_valid | output | 1 | One-clock strobe for sym_data |
| pkt_end | output | 1 | One-clock packet-end pulse |

## Verification
Two functions can fall in the same sample. One is the full-length split of a long space run. The other is the idle detector that closes the packet. Both trigger on a 128-sample boundary, so the last 0x7F space symbol and pkt_end are due together. The bench ends every stimulus pass with a 400-sample space under an idle threshold of 2. It counts the packet-end pulses, and for each one it records whether sym_valid was high in the same clock and whether the symbol was 0x7F. It also checks that exactly three space symbols precede the idle state and that no fourth symbol follows.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
  localparam int NOISE_W = 6;
  localparam int IDLE_W  = 8;
  localparam int LEN_W   = 7;
  localparam int SYM_W   = LEN_W + 1;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  function automatic logic [SYM_W-1:0] pack_sym(input logic lvl, input logic [LEN_W-1:0] len_m1);
    return {lvl, len_m1};
  endfunction

  // true when the sample now seen completes the required persistence
  function automatic logic noise_settled(input logic [NOISE_W-1:0] pend,
                                         input logic [NOISE_W-1:0] thr);
    return ({1'b0, pend} + 1'b1) >= {1'b0, thr};
  endfunction

  // chunk index that closes the packet: completed chunks equal threshold
  function automatic logic idle_reached(input logic [IDLE_W:0] chunks,
                                        input logic [IDLE_W-1:0] thr);
    return chunks == {1'b0, thr};
  endfunction
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic at_last;
  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en || at_last)   cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && at_last;

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end
  endgenerate
endmodule

// File: rtl/ir_sync2.sv
module ir_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end
  assign q = s2_q;
endmodule

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter
  import ir_rl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               lvl_in,
  input  logic [NOISE_W-1:0] thr,
  output logic               filt,
  output logic               flip
);
  logic               filt_q;
  logic [NOISE_W-1:0] pend_q;
  logic               differs, settle;

  assign differs = (lvl_in != filt_q);
  assign settle  = noise_settled(pend_q, thr);
  assign flip    = tick && differs && settle;
  assign filt    = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      pend_q <= '0;
    end else if (!en) begin
      filt_q <= 1'b0;
      pend_q <= '0;
    end else if (tick) begin
      if (!differs) begin
        pend_q <= '0;
      end else if (settle) begin
        filt_q <= lvl_in;
        pend_q <= '0;
      end else begin
        pend_q <= pend_q + 1'b1;
      end
    end
  end

  AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && !$past(tick)) |-> $stable(filt_q)); // R5
endmodule

// File: rtl/ir_run_encoder.sv
module ir_run_encoder
  import ir_rl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              filt,
  input  logic              flip,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic [SYM_W-1:0]  sym_data,
  output logic              sym_valid,
  output logic              pkt_end
);
  logic [LEN_W-1:0] len_q;
  logic [IDLE_W:0]  chunk_q;
  logic             idle_q;
  logic [SYM_W-1:0] sym_q;
  logic             vld_q, pe_q;

  // named internal events
  logic chunk_wrap, idle_hit;
  assign chunk_wrap = tick && !flip && !idle_q && (len_q == LEN_MAX);
  assign idle_hit   = chunk_wrap && !filt && idle_reached(chunk_q, idle_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; chunk_q <= '0; idle_q <= 1'b1;
      sym_q <= '0; vld_q <= 1'b0; pe_q <= 1'b0;
    end else if (!en) begin
      len_q <= '0; chunk_q <= '0; idle_q <= 1'b1;
      vld_q <= 1'b0; pe_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      pe_q  <= 1'b0;
      if (tick) begin
        if (flip) begin
          if (!idle_q) begin
            vld_q <= 1'b1;
            sym_q <= pack_sym(filt, len_q);
          end
          len_q   <= '0;
          chunk_q <= '0;
          idle_q  <= 1'b0;
        end else if (chunk_wrap) begin
          vld_q <= 1'b1;
          sym_q <= pack_sym(filt, LEN_MAX);
          len_q <= '0;
          if (!filt) chunk_q <= chunk_q + 1'b1;
          if (idle_hit) begin
            pe_q   <= 1'b1;
            idle_q <= 1'b1;
          end
        end else if (!idle_q) begin
          len_q <= len_q + 1'b1;
        end
      end
    end
  end

  assign sym_data  = sym_q;
  assign sym_valid = vld_q;
  assign pkt_end   = pe_q;

  AST_NO_SPACE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !$past(idle_q)); // R7
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && en) |=> !sym_valid); // R6
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
  import ir_rl_pkg::*;
#(
  parameter int SAMPLE_DIV = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               rx_en,
  input  logic               pol_inv,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  input  logic               ir_pin,
  output logic [SYM_W-1:0]   sym_data,
  output logic               sym_valid,
  output logic               pkt_end
);
  logic run_en, tick, pin_s, lvl, filt, flip;
  assign run_en = glb_en && rx_en;

  ir_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d(ir_pin), .q(pin_s));
  assign lvl = pin_s ^ pol_inv;

  ir_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick));

  ir_glitch_filter u_filt (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick),
    .lvl_in(lvl), .thr(noise_thr), .filt(filt), .flip(flip));

  ir_run_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick),
    .filt(filt), .flip(flip), .idle_thr(idle_thr),
    .sym_data(sym_data), .sym_valid(sym_valid), .pkt_end(pkt_end));

  AST_SYM_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid || pkt_end) |-> $past(tick)); // R1
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> (!sym_valid && !pkt_end)); // R8
  AST_PKT_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end); // R6
endmodule

// File: tb/sim_ir_runlen_sampler.sv
module sim_ir_runlen_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int IDLE_T = 2;
  localparam int NRUN = 8;
  // {level, samples}; last row is the trailing space that closes the packet
  localparam logic [9:0] RUNS [NRUN] = '{
    {1'b1, 9'd10}, {1'b0, 9'd5}, {1'b1, 9'd200}, {1'b0, 9'd1},
    {1'b1, 9'd128}, {1'b0, 9'd129}, {1'b1, 9'd3}, {1'b0, 9'd400}};

  logic clk = 1'b0, rst_n = 1'b0, glb_en = 1'b0, rx_en = 1'b0, pol_inv = 1'b0;
  logic [5:0] noise_thr = '0;
  logic [7:0] idle_thr = 8'(IDLE_T);
  logic ir_pin = 1'b0, pinv = 1'b0;
  logic [7:0] sym_data;
  logic sym_valid, pkt_end;

  int n_tests = 0, n_fail = 0, pe_cnt = 0, pe_co = 0, cyc = 0;
  bit done = 0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];
  int t7f[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_runlen_sampler #(.SAMPLE_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en), .pol_inv(pol_inv),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_pin(ir_pin),
    .sym_data(sym_data), .sym_valid(sym_valid), .pkt_end(pkt_end));

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sym_valid) begin
        got.push_back(sym_data);
        if (sym_data == 8'h7F) t7f.push_back(cyc);
      end
      if (pkt_end) begin
        pe_cnt++;
        if (sym_valid && sym_data == 8'h7F) pe_co++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    ir_pin = lvl ^ pinv;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic clear_obs();
    got.delete(); exp_q.delete(); t7f.delete(); pe_cnt = 0; pe_co = 0;
  endtask

  // expected symbols of one run of L samples at level l (R2, R3)
  task automatic exp_run(input logic l, input int L);
    for (int k = 0; k < (L - 1) / 128; k++) exp_q.push_back({l, 7'h7F});
    exp_q.push_back({l, 7'((L - 1) % 128)});
  endtask

  task automatic exp_close();
    for (int k = 0; k <= IDLE_T; k++) exp_q.push_back(8'h7F);
  endtask

  task automatic compare(input string req);
    chk({req, " symbol count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk({req, " symbol value"}, got[i], exp_q[i]);
    chk("R6 one packet end", pe_cnt, 1);
    chk("R6 packet end with last 0x7F space symbol", pe_co, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset sym_valid", sym_valid, 0);
    chk("R9 reset pkt_end", pkt_end, 0);
    chk("R9 reset sym_data", sym_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: both polarities (R4), R2 R3 R6 R7
    for (int p = 0; p < 2; p++) begin
      glb_en = 1'b0; rx_en = 1'b0;
      pol_inv = p[0]; pinv = p[0]; ir_pin = p[0];
      repeat (4 * DIV) @(negedge clk);
      glb_en = 1'b1; rx_en = 1'b1;
      repeat (10 * DIV) @(negedge clk);
      clear_obs();
      for (int r = 0; r < NRUN; r++) begin
        drive(RUNS[r][9], int'(RUNS[r][8:0]));
        if (r < NRUN - 1) exp_run(RUNS[r][9], int'(RUNS[r][8:0]));
        else exp_close();
      end
      repeat (5 * DIV) @(negedge clk);
      compare(p ? "R4 inverted R2 R3 R7" : "R2 R3 R7 normal");
      chk("R1 full-chunk spacing", (t7f.size() >= 2) ? t7f[t7f.size()-1] - t7f[t7f.size()-2] : -1,
          128 * DIV);
    end

    // noise suppression R5
    noise_thr = 6'd3;
    clear_obs();
    drive(1, 20); drive(0, 2); drive(1, 20); drive(0, 50); drive(1, 5); drive(0, 400);
    repeat (5 * DIV) @(negedge clk);
    exp_q.push_back(8'hA9); exp_q.push_back(8'h31); exp_q.push_back(8'h84); exp_close();
    compare("R5 glitch absorbed");

    // disabled R8
    noise_thr = 6'd0;
    clear_obs();
    rx_en = 1'b0;
    drive(1, 20); drive(0, 20); drive(1, 20);
    glb_en = 1'b0; rx_en = 1'b1;
    drive(0, 20); drive(1, 20); drive(0, 20);
    chk("R8 no symbols while disabled", got.size(), 0);
    chk("R8 no pkt_end while disabled", pe_cnt, 0);
    glb_en = 1'b1;
    drive(0, 300);
    chk("R7 R8 idle after enable: no space symbol", got.size(), 0);
    chk("R7 idle after enable: no pkt_end", pe_cnt, 0);
    drive(1, 6); drive(0, 2);
    chk("R7 first pulse symbol only", got.size(), 1);
    if (got.size() > 0) chk("R2 first pulse value", got[0], 8'h85);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule